// File: doc/BRIEF.md
# Multichannel Mask Trigger

This block watches a 16-channel logic sample stream and decides when a capture trigger happens. Software-side configuration arrives as three 16-bit masks. The enable mask picks which channels take part. The level mask chooses, per channel, between a level test and an edge test. The polarity mask chooses high versus low for level channels, and falling versus rising for edge channels. After an arm pulse, the block evaluates every sample that arrives on the sample strobe. It emits a single-cycle trigger pulse on the first sample where every enabled channel meets its condition at once.

Only one enabled channel may use an edge test. If the configuration asks for more, a sticky error flag rises and the block does not fire. The block also keeps a captured copy of the most recent sample, gated by a separate capture mask. That mask has no effect on the trigger decision.

Top module: `chan_trigger`

## Requirements
- R1: After synchronous reset, `trig_pulse`, `armed`, `cfg_err` and `cap_word` are all 0.
- R2: An enabled channel whose level bit is 1 matches when its input equals its polarity bit (1 = high, 0 = low).
- R3: An enabled channel whose level bit is 0 matches on a rising edge when its polarity bit is 0, and on a falling edge when its polarity bit is 1. The edge is found by comparing against the previous strobed sample. No edge can match until one sample has been strobed since the last arm.
- R4: The trigger condition is the AND of all enabled channel conditions on the same sample. Channels with enable bit 0 are ignored.
- R5: With an all-zero enable mask, the first strobed sample after arming fires the trigger.
- R6: `trig_pulse` is high for exactly one cycle and at most once per arm. `armed` falls with the pulse, and later matching samples give no pulse until the next arm.
- R7: If more than one channel has enable 1 and level 0, `cfg_err` is set, `armed` is 0 and no pulse occurs. `cfg_err` stays set until reset, or until an arm with a valid configuration.
- R8: On a strobe, `cap_word` takes the sample ANDed with `cap_mask` one cycle later. Without a strobe it holds, and the trigger masks do not affect it.
- R9: A matching strobed sample raises `trig_pulse` in the following cycle. Cycles without a strobe are never evaluated.
- R10: A sample strobed in the same cycle as `arm` is not evaluated for the trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse that starts a trigger search |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Sample word, one bit per channel |
| cap_mask | input | 16 | Channels kept in the captured word |
| trg_en | input | 16 | Trigger enable mask |
| trg_lvl | input | 16 | 1 = level test, 0 = edge test |
| trg_pol | input | 16 | 1 = high/falling, 0 = low/rising |
| trig_pulse | output | 1 | Single-cycle trigger |
| armed | output | 1 | Search in progress |
| cfg_err | output | 1 | Sticky too-many-edge-channels flag |
| cap_word | output | 16 | Last strobed sample, masked |

## Verification
The hardest situation to reach is an edge test combined with level tests on other channels. The edge must land exactly on the sample where the level conditions also hold. At the same time, the first sample after arming must not produce a false edge from stale history. The vector table reaches this by giving each case two strobed samples after an arm. The first sample primes the history and is checked for firing too early. The second sample carries the edge, so every case shows both the primed sample and the firing sample.

// File: rtl/ctrg_pkg.sv
package ctrg_pkg;
    localparam int CH_N  = 16;
    localparam int CNT_W = $clog2(CH_N) + 1;

    typedef struct packed {
        logic [CH_N-1:0] en;
        logic [CH_N-1:0] lvl;
        logic [CH_N-1:0] pol;
    } trig_cfg_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_ARMED = 1'b1} ctrl_st_t;

    function automatic logic [CNT_W-1:0] edge_count(input trig_cfg_t c);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < CH_N; i++)
            n = n + CNT_W'(c.en[i] & ~c.lvl[i]);
        return n;
    endfunction
endpackage

// File: rtl/ctrg_history.sv
module ctrg_history
    import ctrg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  logic            smp_valid,
    input  logic [CH_N-1:0] smp_data,
    output logic [CH_N-1:0] prev,
    output logic            hist_vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= '0;
            hist_vld <= 1'b0;
        end else if (arm) begin
            hist_vld <= 1'b0;
        end else if (smp_valid) begin
            prev     <= smp_data;
            hist_vld <= 1'b1;
        end
    end

    // R3: history is discarded by every arm
    p_hist_clear_r3: assert property (@(posedge clk) disable iff (rst)
        arm |=> !hist_vld);
endmodule

// File: rtl/ctrg_match.sv
module ctrg_match
    import ctrg_pkg::*;
(
    input  trig_cfg_t       cfg,
    input  logic [CH_N-1:0] cur,
    input  logic [CH_N-1:0] prev,
    input  logic            hist_vld,
    output logic            all_match
);
    logic [CH_N-1:0] hit;

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        always_comb begin
            if (!cfg.en[i])
                hit[i] = 1'b1;
            else if (cfg.lvl[i])
                hit[i] = (cur[i] == cfg.pol[i]);
            else if (cfg.pol[i])
                hit[i] = hist_vld & prev[i] & ~cur[i];
            else
                hit[i] = hist_vld & ~prev[i] & cur[i];
        end
    end

    assign all_match = &hit;
endmodule

// File: rtl/ctrg_ctrl.sv
module ctrg_ctrl
    import ctrg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic smp_valid,
    input  logic all_match,
    input  logic cfg_bad,
    output logic trig_pulse,
    output logic armed,
    output logic cfg_err
);
    ctrl_st_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            trig_pulse <= 1'b0;
            cfg_err    <= 1'b0;
        end else begin
            trig_pulse <= 1'b0;
            if (arm) begin
                cfg_err <= cfg_bad;
                st      <= cfg_bad ? ST_IDLE : ST_ARMED;
            end else if (st == ST_ARMED) begin
                if (cfg_bad) begin
                    cfg_err <= 1'b1;
                    st      <= ST_IDLE;
                end else if (smp_valid && all_match) begin
                    trig_pulse <= 1'b1;
                    st         <= ST_IDLE;
                end
            end
        end
    end

    assign armed = (st == ST_ARMED);

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);
    p_disarm_on_fire_r6: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> !armed);
    p_no_fire_on_err_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !trig_pulse);
    p_fire_needs_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(smp_valid));
    p_arm_cycle_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        arm |=> !trig_pulse);
endmodule

// File: rtl/chan_trigger.sv
module chan_trigger
    import ctrg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  logic            smp_valid,
    input  logic [CH_N-1:0] smp_data,
    input  logic [CH_N-1:0] cap_mask,
    input  logic [CH_N-1:0] trg_en,
    input  logic [CH_N-1:0] trg_lvl,
    input  logic [CH_N-1:0] trg_pol,
    output logic            trig_pulse,
    output logic            armed,
    output logic            cfg_err,
    output logic [CH_N-1:0] cap_word
);
    trig_cfg_t       cfg;
    logic [CH_N-1:0] prev;
    logic            hist_vld;
    logic            all_match;
    logic            cfg_bad;

    assign cfg     = '{en: trg_en, lvl: trg_lvl, pol: trg_pol};
    assign cfg_bad = (edge_count(cfg) > CNT_W'(1));

    ctrg_history u_hist (
        .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid),
        .smp_data(smp_data), .prev(prev), .hist_vld(hist_vld)
    );

    ctrg_match u_match (
        .cfg(cfg), .cur(smp_data), .prev(prev), .hist_vld(hist_vld),
        .all_match(all_match)
    );

    ctrg_ctrl u_ctrl (
        .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid),
        .all_match(all_match), .cfg_bad(cfg_bad),
        .trig_pulse(trig_pulse), .armed(armed), .cfg_err(cfg_err)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cap_word <= '0;
        else if (smp_valid)
            cap_word <= smp_data & cap_mask;
    end

    p_cap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(cap_word));
endmodule

// File: tb/chan_trigger_bench.sv
module chan_trigger_bench;
    logic        clk = 1'b0;
    logic        rst, arm, smp_valid;
    logic [15:0] smp_data, cap_mask, trg_en, trg_lvl, trg_pol;
    logic        trig_pulse, armed, cfg_err;
    logic [15:0] cap_word;
    int          n_tests = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    chan_trigger u_chan_trigger (
        .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid),
        .smp_data(smp_data), .cap_mask(cap_mask), .trg_en(trg_en),
        .trg_lvl(trg_lvl), .trg_pol(trg_pol), .trig_pulse(trig_pulse),
        .armed(armed), .cfg_err(cfg_err), .cap_word(cap_word)
    );

    // {en, lvl, pol, first sample, second sample, fire point 0=none 1=first 2=second}
    localparam logic [81:0] VEC [10] = '{
        {16'h0001, 16'h0001, 16'h0001, 16'h0000, 16'h0001, 2'd2}, // R2 high
        {16'h0001, 16'h0001, 16'h0000, 16'h0001, 16'h0000, 2'd2}, // R2 low
        {16'h0004, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 2'd2}, // R3 rise
        {16'h0004, 16'h0000, 16'h0004, 16'h0004, 16'h0000, 2'd2}, // R3 fall
        {16'h0004, 16'h0000, 16'h0000, 16'h0004, 16'h0004, 2'd0}, // R3 no edge
        {16'h0003, 16'h0003, 16'h0003, 16'h0001, 16'h0003, 2'd2}, // R4 and
        {16'h8001, 16'h8000, 16'h8000, 16'h8000, 16'h8001, 2'd2}, // R4 mixed
        {16'h0000, 16'h0000, 16'h0000, 16'h1234, 16'h5678, 2'd1}, // R5 empty
        {16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 2'd1}, // R6 once
        {16'h0010, 16'h0010, 16'h0010, 16'hFFEF, 16'h0010, 2'd2}  // R4 ignore
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [15:0] d);
        @(negedge clk); smp_valid = 1'b1; smp_data = d;
        @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic arm_it();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    initial begin
        rst = 1'b1; arm = 1'b0; smp_valid = 1'b0; smp_data = '0;
        cap_mask = 16'hFFFF; trg_en = '0; trg_lvl = '0; trg_pol = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pulse", trig_pulse, 0);
        check("R1 armed", armed, 0);
        check("R1 err", cfg_err, 0);
        check("R1 cap", cap_word, 0);

        for (int k = 0; k < 10; k++) begin
            logic got0, got1;
            logic [1:0] fire_at;
            trg_en = VEC[k][81:66]; trg_lvl = VEC[k][65:50]; trg_pol = VEC[k][49:34];
            fire_at = VEC[k][1:0];
            arm_it();
            strobe(VEC[k][33:18]); got0 = trig_pulse;
            strobe(VEC[k][17:2]);  got1 = trig_pulse;
            check($sformatf("R2-table vec%0d first", k), got0, fire_at == 2'd1);
            check($sformatf("R3-table vec%0d second", k), got1, fire_at == 2'd2);
        end

        // R6: pulse lasts one cycle and disarms
        trg_en = 16'h0001; trg_lvl = 16'h0001; trg_pol = 16'h0001;
        arm_it();
        strobe(16'h0001);
        check("R6 pulse", trig_pulse, 1);
        check("R6 disarm", armed, 0);
        @(negedge clk);
        check("R6 one cycle", trig_pulse, 0);

        // R9: matching data without strobe is not evaluated
        arm_it();
        smp_data = 16'h0001;
        repeat (3) begin
            @(negedge clk);
            check("R9 no strobe", trig_pulse, 0);
        end
        check("R9 still armed", armed, 1);
        strobe(16'h0001);
        check("R9 fires", trig_pulse, 1);

        // R10: sample in the arm cycle is not evaluated
        @(negedge clk); arm = 1'b1; smp_valid = 1'b1; smp_data = 16'h0001;
        @(negedge clk); arm = 1'b0; smp_valid = 1'b0;
        check("R10 arm cycle", trig_pulse, 0);
        check("R10 armed", armed, 1);
        strobe(16'h0001);
        check("R10 next fires", trig_pulse, 1);

        // R7: two edge channels
        trg_en = 16'h0006; trg_lvl = 16'h0000; trg_pol = 16'h0000;
        arm_it();
        check("R7 err set", cfg_err, 1);
        check("R7 not armed", armed, 0);
        strobe(16'h0000);
        strobe(16'h0006);
        check("R7 no fire", trig_pulse, 0);
        check("R7 sticky", cfg_err, 1);
        // disabled channel with level 0 is not counted
        trg_en = 16'h0002; trg_lvl = 16'h0000;
        arm_it();
        check("R7 cleared", cfg_err, 0);
        check("R7 armed ok", armed, 1);
        // going bad while armed
        trg_en = 16'h0003;
        @(negedge clk);
        check("R7 mid err", cfg_err, 1);
        check("R7 mid disarm", armed, 0);

        // R8: capture mask
        cap_mask = 16'h00FF;
        strobe(16'hABCD);
        check("R8 capture", cap_word, 16'h00CD);
        smp_data = 16'h1111; trg_en = 16'hFFFF; trg_lvl = 16'hFFFF;
        @(negedge clk);
        check("R8 hold", cap_word, 16'h00CD);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule